// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog that software must service inside a closing window at the end of each timeout period. A simple register port (address, write data, write enable, combinational read data) gives access to control, preload, key, window, reaction, status and live-count registers. Software first programs a 12-bit coarse preload. It then arms the timer with a fixed 32-bit word. From then on a down-counter runs from the preload scaled by a power of two.

Servicing takes two key words written in order. The second word counts only while the remaining count lies inside the last selected fraction of the period. A service that comes too early, a second key with no first key before it, or any other word on the key register is a violation. The block treats a violation the same way as expiry. Each such event produces a one-cycle pulse on either the reset output or the non-maskable interrupt output, as the reaction register selects. A sticky status bit records the cause.

Top module: `win_wdog`

## Requirements
- R1: After reset the block is disarmed, both outputs are low, and the reads are: control 0, preload 0xFFF, window 0, reaction 0, status 0, count 0.
- R2: Writing 0xA98559DA to the control register (0x90) while disarmed arms the timer, and control then reads back that word. Any other control word is ignored. Once armed, no write disarms the timer.
- R3: Arming or servicing loads the counter with the 12-bit preload (0x94) shifted left by PRE_SHIFT. While armed the counter drops by one each cycle, and its value is readable at 0xA0.
- R4: When the count is zero, the cycle after that produces one single-cycle reaction pulse and sets status bit 1 (0x98). The counter then stays at zero, and later key writes are ignored.
- R5: Writing 0xE51A to the key register (0x9C) makes a service pending. A following 0xA35C, written while the count is inside the open window, reloads the counter and raises no reaction.
- R6: The window register (0xA8) sets the open window to the final fraction of the loaded period: 0x50 gives 1/2, 0x500 gives 1/4, 0x5000 gives 1/8, 0x50000 gives 1/16 and 0x500000 gives 1/32. A count equal to reload >> n is inside the window.
- R7: Each of these is a violation, which sets status bit 0 and produces a reaction pulse in the cycle after the write: a 0xA35C written while the count is above the window, a 0xA35C written with no pending 0xE51A, or any other word written to the key register.
- R8: When the reaction register (0xA4) holds 0xA, events pulse the interrupt output (nmi_o). For any other value they pulse the reset output (rst_o). The two outputs are never high together.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: Writes to the preload and window registers take effect only at the next reload.
- R11: A window value that matches none of the listed encodings gives a fully open window.
- R12: While disarmed the count stays at zero and key writes have no effect.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Register byte offset |
| wdata_i | input | DW | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | DW | Read data for addr_i |
| rst_o | output | 1 | Reset reaction pulse |
| nmi_o | output | 1 | Interrupt reaction pulse |

## Verification
Several properties are checked on every cycle: the armed flag stays set once it is set, the count falls by exactly one per armed cycle, the count holds at zero after expiry and stays at zero while disarmed, a service reloads the scaled preload, the two reaction outputs are never high together, and every pulse coincides with a set status bit. Other behaviour needs directed scenarios. These cover the exact boundary of each window encoding and the count one above it, expiry timing measured from arming, the choice of reaction output, the deferred effect of preload changes, write-one-to-clear, and keys ignored after expiry or before arming.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_CTRL    = 8'h90;
  localparam logic [7:0] OFF_PRELOAD = 8'h94;
  localparam logic [7:0] OFF_STATUS  = 8'h98;
  localparam logic [7:0] OFF_KEY     = 8'h9C;
  localparam logic [7:0] OFF_CNT     = 8'hA0;
  localparam logic [7:0] OFF_REACT   = 8'hA4;
  localparam logic [7:0] OFF_WIN     = 8'hA8;

  localparam logic [31:0] ARM_WORD   = 32'hA985_59DA;
  localparam logic [31:0] KEY_FIRST  = 32'h0000_E51A;
  localparam logic [31:0] KEY_SECOND = 32'h0000_A35C;
  localparam logic [31:0] REACT_NMI  = 32'h0000_000A;

  localparam int ST_KEY_BIT = 0;
  localparam int ST_EXP_BIT = 1;

  typedef enum logic {KEY_IDLE, KEY_PEND} key_st_e;

  // window code -> right shift of the loaded period; 0 means fully open
  function automatic logic [2:0] win_shift(input logic [31:0] code);
    case (code)
      32'h0000_0050: win_shift = 3'd1;
      32'h0000_0500: win_shift = 3'd2;
      32'h0000_5000: win_shift = 3'd3;
      32'h0005_0000: win_shift = 3'd4;
      32'h0050_0000: win_shift = 3'd5;
      default:       win_shift = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          armed_i,
  input  logic          reload_i,
  input  logic [CW-1:0] reload_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;
  logic          expired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q <= reload_val_i;
    end else if (armed_i && !expired_q) begin
      if (cnt_q == '0) expired_q <= 1'b1;
      else             cnt_q     <= cnt_q - CW'(1);
    end
  end

  assign expire_o  = armed_i && !expired_q && (cnt_q == '0) && !reload_i;
  assign cnt_o     = cnt_q;
  assign expired_o = expired_q;

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !expired_q && cnt_q != '0 && !reload_i) |=> cnt_q == $past(cnt_q) - CW'(1)); // R3
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && !reload_i) |=> (cnt_q == '0 && expired_q)); // R4
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CW = 25
) (
  input  logic [CW-1:0] reload_i,
  input  logic [2:0]    shift_i,
  input  logic [CW-1:0] cnt_i,
  output logic          in_win_o
);
  logic [CW-1:0] thr [8];

  for (genvar g = 0; g < 8; g++) begin : g_thr
    assign thr[g] = reload_i >> g;
  end

  assign in_win_o = (cnt_i <= thr[shift_i]);
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          live_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          in_win_i,
  output logic          service_o,
  output logic          violation_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    service_o   = 1'b0;
    violation_o = 1'b0;
    if (wr_i && live_i) begin
      if (data_i == DW'(KEY_FIRST)) begin
        st_d = KEY_PEND;
      end else if (data_i == DW'(KEY_SECOND) && st_q == KEY_PEND && in_win_i) begin
        service_o = 1'b1;
        st_d      = KEY_IDLE;
      end else begin
        violation_o = 1'b1;
        st_d        = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  AST_NO_SVC_WHEN_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_i |-> (!service_o && !violation_o)); // R12
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdog_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int PRE_W     = 12,
  parameter int PRE_SHIFT = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_o,
  output logic          nmi_o
);
  localparam int CW = PRE_W + PRE_SHIFT;

  logic             armed_q;
  logic [PRE_W-1:0] preload_q;
  logic [DW-1:0]    win_q, react_q;
  logic [CW-1:0]    act_reload_q;
  logic [2:0]       act_shift_q;
  logic [1:0]       stat_q, stat_d;

  logic [CW-1:0] cnt, reload_val;
  logic          expire, expired, in_win, service, violation;
  logic          wr_ctrl, wr_pre, wr_stat, wr_key, wr_react, wr_win;
  logic          arm_ev, reload, live, event_any, nmi_sel;

  assign wr_ctrl  = we_i && addr_i == AW'(OFF_CTRL);
  assign wr_pre   = we_i && addr_i == AW'(OFF_PRELOAD);
  assign wr_stat  = we_i && addr_i == AW'(OFF_STATUS);
  assign wr_key   = we_i && addr_i == AW'(OFF_KEY);
  assign wr_react = we_i && addr_i == AW'(OFF_REACT);
  assign wr_win   = we_i && addr_i == AW'(OFF_WIN);

  assign arm_ev     = wr_ctrl && !armed_q && wdata_i == DW'(ARM_WORD);
  assign reload_val = CW'(preload_q) << PRE_SHIFT;
  assign reload     = arm_ev || service;
  assign live       = armed_q && !expired && cnt != '0;
  assign event_any  = expire || violation;
  assign nmi_sel    = react_q == DW'(REACT_NMI);

  wdog_counter #(.CW(CW)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .armed_i      (armed_q),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .cnt_o        (cnt),
    .expire_o     (expire),
    .expired_o    (expired)
  );

  wdog_window #(.CW(CW)) u_win (
    .reload_i (act_reload_q),
    .shift_i  (act_shift_q),
    .cnt_i    (cnt),
    .in_win_o (in_win)
  );

  wdog_key_fsm #(.DW(DW)) u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .live_i      (live),
    .wr_i        (wr_key),
    .data_i      (wdata_i),
    .in_win_i    (in_win),
    .service_o   (service),
    .violation_o (violation)
  );

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~wdata_i[1:0];
    if (expire)    stat_d[ST_EXP_BIT] = 1'b1;
    if (violation) stat_d[ST_KEY_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      preload_q    <= '1;
      win_q        <= '0;
      react_q      <= '0;
      act_reload_q <= '0;
      act_shift_q  <= '0;
      stat_q       <= '0;
      rst_o        <= 1'b0;
      nmi_o        <= 1'b0;
    end else begin
      if (arm_ev)   armed_q   <= 1'b1;
      if (wr_pre)   preload_q <= wdata_i[PRE_W-1:0];
      if (wr_win)   win_q     <= wdata_i;
      if (wr_react) react_q   <= wdata_i;
      if (reload) begin
        act_reload_q <= reload_val;
        act_shift_q  <= win_shift(32'(win_q));
      end
      stat_q <= stat_d;
      rst_o  <= event_any && !nmi_sel;
      nmi_o  <= event_any && nmi_sel;
    end
  end

  always_comb begin
    case (addr_i)
      AW'(OFF_CTRL):    rdata_o = armed_q ? DW'(ARM_WORD) : '0;
      AW'(OFF_PRELOAD): rdata_o = DW'(preload_q);
      AW'(OFF_STATUS):  rdata_o = DW'(stat_q);
      AW'(OFF_CNT):     rdata_o = DW'(cnt);
      AW'(OFF_REACT):   rdata_o = react_q;
      AW'(OFF_WIN):     rdata_o = win_q;
      default:          rdata_o = '0;
    endcase
  end

  AST_ARMED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> cnt == '0); // R12
  AST_SERVICE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service |=> cnt == $past(reload_val)); // R5
  AST_ONE_REACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_o && nmi_o)); // R8
  AST_PULSE_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o || nmi_o) |-> stat_q != '0); // R4
endmodule

// File: tb/win_wdog_test.sv
module win_wdog_test;
  import wdog_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rst_o, nmi_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  win_wdog #(.PRE_SHIFT(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .rst_o(rst_o), .nmi_o(nmi_o)
  );

  // {window code, valid service count, early count (0 = none)}; preload 8, shift 2 -> period 32
  localparam logic [95:0] VEC [0:6] = '{
    {32'h0000_0050, 32'd16, 32'd17},
    {32'h0000_0500, 32'd8,  32'd9},
    {32'h0000_5000, 32'd4,  32'd5},
    {32'h0005_0000, 32'd2,  32'd3},
    {32'h0050_0000, 32'd1,  32'd2},
    {32'h0000_0000, 32'd28, 32'd0},
    {32'h0000_0007, 32'd28, 32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic key2_at(input logic [31:0] target);
    logic [31:0] v;
    for (int g = 0; g < 400; g++) begin
      rd(OFF_CNT, v);
      if (v == target) break;
      @(negedge clk_i);
    end
    wr(OFF_KEY, KEY_SECOND);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int k;
    do_reset();

    // R1 reset state
    check("R1 rst_o", 32'(rst_o), 0);
    check("R1 nmi_o", 32'(nmi_o), 0);
    rd(OFF_CTRL, v);    check("R1 ctrl", v, 0);
    rd(OFF_PRELOAD, v); check("R1 preload", v, 32'hFFF);
    rd(OFF_WIN, v);     check("R1 window", v, 0);
    rd(OFF_REACT, v);   check("R1 react", v, 0);
    rd(OFF_STATUS, v);  check("R1 status", v, 0);
    rd(OFF_CNT, v);     check("R1 cnt", v, 0);

    // R12 disarmed: no count, keys ignored
    repeat (5) @(negedge clk_i);
    rd(OFF_CNT, v); check("R12 cnt idle", v, 0);
    wr(OFF_KEY, 32'h1234);
    check("R12 no pulse", 32'(rst_o), 0);
    rd(OFF_STATUS, v); check("R12 status", v, 0);

    // R2 wrong arm word ignored, then arm
    wr(OFF_CTRL, 32'h1234_5678);
    rd(OFF_CTRL, v); check("R2 bad arm ignored", v, 0);
    wr(OFF_PRELOAD, 32'd3);
    rd(OFF_PRELOAD, v); check("R3 preload readback", v, 3);
    wr(OFF_CTRL, ARM_WORD);
    rd(OFF_CTRL, v); check("R2 armed readback", v, ARM_WORD);
    // R3 reload 3<<2 = 12, decrements per cycle
    rd(OFF_CNT, v); check("R3 cnt after arm", v, 12);
    @(negedge clk_i);
    rd(OFF_CNT, v); check("R3 cnt decrement", v, 11);

    // R4 expiry timing measured from arm
    do_reset();
    wr(OFF_PRELOAD, 32'd3);
    wr(OFF_CTRL, ARM_WORD);
    k = 0;
    while (!rst_o && k < 1000) begin @(negedge clk_i); k++; end
    check("R4 expiry cycle", 32'(k), 13);
    @(negedge clk_i);
    check("R4 single-cycle pulse", 32'(rst_o), 0);
    rd(OFF_STATUS, v); check("R4 status expired", v, 2);
    repeat (4) @(negedge clk_i);
    rd(OFF_CNT, v); check("R4 cnt held at zero", v, 0);
    wr(OFF_KEY, 32'h1234);
    check("R4 key ignored after expiry", 32'(rst_o), 0);
    rd(OFF_STATUS, v); check("R4 status unchanged", v, 2);
    wr(OFF_CTRL, 32'h0);
    rd(OFF_CTRL, v); check("R2 no disarm", v, ARM_WORD);
    // R9 write-one-to-clear
    wr(OFF_STATUS, 32'h1);
    rd(OFF_STATUS, v); check("R9 other bit kept", v, 2);
    wr(OFF_STATUS, 32'h2);
    rd(OFF_STATUS, v); check("R9 cleared", v, 0);

    // R8 interrupt reaction
    do_reset();
    wr(OFF_REACT, REACT_NMI);
    wr(OFF_PRELOAD, 32'd1);
    wr(OFF_CTRL, ARM_WORD);
    k = 0;
    while (!nmi_o && !rst_o && k < 1000) begin @(negedge clk_i); k++; end
    check("R8 nmi pulse", 32'(nmi_o), 1);
    check("R8 no reset pulse", 32'(rst_o), 0);
    check("R8 nmi timing", 32'(k), 5);

    // R7 bad key word, second key without first
    do_reset();
    wr(OFF_PRELOAD, 32'd8);
    wr(OFF_CTRL, ARM_WORD);
    wr(OFF_KEY, 32'h1234);
    check("R7 bad word pulse", 32'(rst_o), 1);
    rd(OFF_STATUS, v); check("R7 bad word status", v, 1);
    wr(OFF_STATUS, 32'h1);
    wr(OFF_KEY, KEY_SECOND);
    check("R7 lone second key pulse", 32'(rst_o), 1);
    rd(OFF_STATUS, v); check("R7 lone second key status", v, 1);

    // R10 preload change deferred to next reload
    do_reset();
    wr(OFF_PRELOAD, 32'd4);
    wr(OFF_CTRL, ARM_WORD);
    wr(OFF_PRELOAD, 32'd8);
    rd(OFF_CNT, v); check("R10 running count unchanged", v, 15);
    wr(OFF_KEY, KEY_FIRST);
    wr(OFF_KEY, KEY_SECOND);
    rd(OFF_CNT, v); check("R10 new preload at reload", v, 32);

    // R6/R11 window table walk
    for (int i = 0; i < 7; i++) begin
      logic [31:0] code, vok, vearly;
      {code, vok, vearly} = VEC[i];
      do_reset();
      wr(OFF_PRELOAD, 32'd8);
      wr(OFF_WIN, code);
      wr(OFF_CTRL, ARM_WORD);
      wr(OFF_KEY, KEY_FIRST);
      key2_at(vok);
      check(i >= 5 ? "R11 open service no pulse" : "R6 boundary service no pulse", 32'(rst_o), 0);
      rd(OFF_CNT, v); check("R5 service reloads", v, 32);
      rd(OFF_STATUS, v); check("R6 status clean", v, 0);
      if (vearly != 0) begin
        wr(OFF_KEY, KEY_FIRST);
        key2_at(vearly);
        check("R7 early service pulse", 32'(rst_o), 1);
        rd(OFF_STATUS, v); check("R7 early service status", v, 1);
      end
    end

    finish_run();
  end
endmodule